// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received frames as a byte stream and stores them in main memory. Memory is split into fixed 128-byte buffers. Each buffer is described by a two-word descriptor, and the descriptors form a ring that lives in the same memory. When a frame starts, the engine fetches the current descriptor and checks that the MAC side owns it. It then packs the frame bytes into 32-bit words and writes them into the buffer. When the buffer is full or the frame ends, it writes a status word back to the descriptor, sets the ownership bit to pass the buffer to software, and moves to the next descriptor. A frame longer than one buffer continues in the descriptors that follow.

Software builds the ring before it enables reception. It clears the ownership bit of every entry and sets the wrap bit on the last entry when the ring has fewer than the maximum number of entries. It then loads the ring start address while reception is disabled. If the engine finds a descriptor that software still holds, it stops. It discards the rest of that frame and raises a buffer-not-available flag. It stays stopped until reception is switched off.

The byte input and the memory request both use valid/ready handshakes. The source must hold `in_valid`, `in_data`, `in_sof` and `in_eof` steady until `in_ready` is high at a clock edge. The engine holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_gnt` is high at a clock edge. Read data is taken on a later cycle that has `mem_rvalid` high. The receive enable, the queue pointer write port and the flag output are plain level signals with no handshake.

Top module: `rxq_ring_dma`

## Requirements
- R1: A frame starts with a byte that has `in_sof` high, arriving while the engine is idle and `rx_en` is high. The engine holds that byte (`in_ready` low) and reads word 0 of the current descriptor. Bit 0 of word 0 is ownership, where 0 means the MAC may fill the buffer. Bits [31:2] give the word-aligned buffer base address.
- R2: Byte i of a buffer goes to the word at base + 4*(i/4), in bits [8*(i%4)+7 : 8*(i%4)], so the packing is little-endian. In the last, partly used word of a buffer, the unused upper byte lanes are written as zero. Words past the last used word are not written.
- R3: A buffer holds at most 128 bytes. A longer frame continues at byte 0 of the next descriptor in the ring.
- R4: When a buffer is closed, descriptor word 1 (address + 4) is written before word 0. Word 1 bits [15:0] hold the frame's byte count up to the end of this buffer. Bit 30 is set only on the frame's first buffer, bit 31 only on its last buffer, and all other bits are zero.
- R5: Word 0 is written back as the value that was fetched, with bit 0 set to 1.
- R6: After a descriptor is handed over, the next descriptor is the ring start if bit 1 (wrap) of its word 0 was set, or if it was entry 1024 of the ring. Otherwise the next descriptor is at the current address + 8.
- R7: A fetched word 0 with bit 0 set means software still holds the buffer. In that case:
  - nothing is written to memory;
  - `bna` goes high;
  - the rest of the frame, and any later input, is accepted and discarded;
  - once `rx_en` is low, `bna` clears and the engine goes idle;
  - after re-enabling, the engine fetches the same descriptor again.
- R8: A queue pointer write is taken only when `rx_en` is low and the engine is idle; at any other time it is ignored. A taken write sets both the ring start and the current descriptor to the written address.
- R9: While the engine is idle, a byte without `in_sof`, or any byte while `rx_en` is low, is accepted and dropped without any memory access.
- R10: A memory request holds its address, direction and write data until it is granted. Every address is word-aligned. No input byte is accepted while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| qptr_we | input | 1 | Queue pointer write strobe |
| qptr_wdata | input | 32 | Ring start address |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is first of a frame |
| in_eof | input | 1 | Byte is last of a frame |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| bna | output | 1 | Buffer not available, engine stopped |

## Verification
If the ring index or current address is wrong, the next frame is written into the wrong buffer or descriptor. That shows up in memory as soon as the frame's status writes complete. A byte-offset error either moves data to the wrong lanes or leaves stale words in the buffer, which shows up within the same buffer. A wrong ownership or stop state shows up as writes that should not occur, or as `bna` high or low at the wrong moment. The implicit wrap after 1024 entries can only be seen after a complete pass of a full ring, so a full pass is run and a sentinel descriptor is placed just past the last entry.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_FILL,
    ST_WDATA,
    ST_WSTAT1,
    ST_WSTAT0,
    ST_DROP,
    ST_HALT
  } rxq_state_e;

  localparam int unsigned OWN_BIT      = 0;
  localparam int unsigned WRAP_BIT     = 1;
  localparam int unsigned SOF_FLAG_BIT = 30;
  localparam int unsigned EOF_FLAG_BIT = 31;
  localparam int unsigned CNT_W        = 16;
  localparam int unsigned DESC_STRIDE  = 8;
  localparam int unsigned STAT_OFFSET  = 4;
endpackage

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int unsigned AW       = 32,
  parameter int unsigned RING_MAX = 1024,
  parameter int unsigned STRIDE   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic          advance,
  input  logic          wrap_flag,
  output logic [AW-1:0] desc_addr
);
  localparam int unsigned IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;

  logic [AW-1:0]    ring_base;
  logic [AW-1:0]    cur_addr;
  logic [IDX_W-1:0] ring_idx;
  logic             at_last;

  assign at_last   = (ring_idx == IDX_W'(RING_MAX - 1));
  assign desc_addr = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_base <= '0;
      cur_addr  <= '0;
      ring_idx  <= '0;
    end else if (load) begin
      ring_base <= load_base;
      cur_addr  <= load_base;
      ring_idx  <= '0;
    end else if (advance) begin
      if (wrap_flag || at_last) begin
        cur_addr <= ring_base;
        ring_idx <= '0;
      end else begin
        cur_addr <= cur_addr + AW'(STRIDE);
        ring_idx <= ring_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxq_word_pack.sv
module rxq_word_pack #(
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  push,
  input  logic [7:0]            byte_in,
  output logic [DW-1:0]         word,
  output logic [$clog2(BUF_BYTES)-3:0] word_idx,
  output logic                  last_in_word,
  output logic                  last_in_buf
);
  localparam int unsigned LANES  = DW / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned OFF_W  = $clog2(BUF_BYTES);

  logic [OFF_W-1:0]  off;
  logic [LANE_W-1:0] lane;
  logic [DW-1:0]     acc;

  assign lane         = off[LANE_W-1:0];
  assign last_in_word = (lane == LANE_W'(LANES - 1));
  assign last_in_buf  = (off == OFF_W'(BUF_BYTES - 1));
  assign word         = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off      <= '0;
      word_idx <= '0;
    end else if (clr) begin
      off      <= '0;
    end else if (push) begin
      off      <= off + 1'b1;
      word_idx <= off[OFF_W-1:LANE_W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[8*g +: 8] <= '0;
      end else if (push) begin
        if (lane == LANE_W'(g)) begin
          acc[8*g +: 8] <= byte_in;
        end else if (lane == '0) begin
          acc[8*g +: 8] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rxq_rx_ctrl.sv
module rxq_rx_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_BYTES = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          in_ready,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] desc_addr,
  input  logic [DW-1:0] pack_word,
  input  logic [$clog2(BUF_BYTES)-3:0] pack_widx,
  input  logic          pack_last_word,
  input  logic          pack_last_buf,
  output logic          pack_push,
  output logic          pack_clr,
  output logic          ptr_advance,
  output logic          ptr_wrap,
  output logic          load_ok,
  output logic          bna
);
  localparam int unsigned WIDX_W = $clog2(BUF_BYTES) - 2;

  rxq_state_e       state;
  logic [DW-1:0]    w0;
  logic             first_buf;
  logic             eof_seen;
  logic             buf_full;
  logic [CNT_W-1:0] frame_cnt;
  logic             in_accept;
  logic [AW-1:0]    buf_base;
  logic [DW-1:0]    status_word;
  logic [AW-1:0]    data_addr;

  always_comb begin
    case (state)
      ST_IDLE:                    in_ready = !(rx_en && in_sof);
      ST_FILL, ST_DROP, ST_HALT:  in_ready = 1'b1;
      default:                    in_ready = 1'b0;
    endcase
  end

  assign in_accept = in_valid && in_ready;
  assign pack_push = (state == ST_FILL) && in_accept;
  assign buf_base  = {w0[AW-1:2], 2'b00};
  assign data_addr = buf_base + AW'({pack_widx, 2'b00});

  always_comb begin
    status_word               = '0;
    status_word[CNT_W-1:0]    = frame_cnt;
    status_word[SOF_FLAG_BIT] = first_buf;
    status_word[EOF_FLAG_BIT] = eof_seen;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (state)
      ST_FETCH: begin
        mem_req = 1'b1;
      end
      ST_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = data_addr;
        mem_wdata = pack_word;
      end
      ST_WSTAT1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(STAT_OFFSET);
        mem_wdata = status_word;
      end
      ST_WSTAT0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = w0 | DW'(1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign pack_clr    = (state == ST_WSTAT0) && mem_gnt;
  assign ptr_advance = pack_clr;
  assign ptr_wrap    = w0[WRAP_BIT];
  assign load_ok     = (state == ST_IDLE) && !rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      w0        <= '0;
      first_buf <= 1'b0;
      eof_seen  <= 1'b0;
      buf_full  <= 1'b0;
      frame_cnt <= '0;
      bna       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rx_en && in_valid && in_sof) begin
            first_buf <= 1'b1;
            eof_seen  <= 1'b0;
            buf_full  <= 1'b0;
            frame_cnt <= '0;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_gnt) state <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (mem_rvalid) begin
            if (mem_rdata[OWN_BIT]) begin
              bna   <= 1'b1;
              state <= ST_DROP;
            end else begin
              w0    <= mem_rdata;
              state <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (in_accept) begin
            frame_cnt <= frame_cnt + 1'b1;
            if (pack_last_word || pack_last_buf || in_eof) begin
              eof_seen <= in_eof;
              buf_full <= pack_last_buf;
              state    <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (mem_gnt) begin
            state <= (eof_seen || buf_full) ? ST_WSTAT1 : ST_FILL;
          end
        end
        ST_WSTAT1: begin
          if (mem_gnt) state <= ST_WSTAT0;
        end
        ST_WSTAT0: begin
          if (mem_gnt) begin
            first_buf <= 1'b0;
            buf_full  <= 1'b0;
            state     <= eof_seen ? ST_IDLE : ST_FETCH;
          end
        end
        ST_DROP: begin
          if (in_accept && in_eof) state <= ST_HALT;
        end
        ST_HALT: begin
          if (!rx_en) begin
            bna   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_widx;
  assign unused_widx = ^{WIDX_W'(0)};
endmodule

// File: rtl/rxq_ring_dma.sv
module rxq_ring_dma #(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned RING_MAX  = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          qptr_we,
  input  logic [AW-1:0] qptr_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          bna
);
  localparam int unsigned WIDX_W = $clog2(BUF_BYTES) - 2;

  logic [AW-1:0]     desc_addr;
  logic [DW-1:0]     pack_word;
  logic [WIDX_W-1:0] pack_widx;
  logic              pack_last_word;
  logic              pack_last_buf;
  logic              pack_push;
  logic              pack_clr;
  logic              ptr_advance;
  logic              ptr_wrap;
  logic              load_ok;

  rxq_ring_ptr #(
    .AW       (AW),
    .RING_MAX (RING_MAX),
    .STRIDE   (rxq_pkg::DESC_STRIDE)
  ) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (qptr_we && load_ok),
    .load_base (qptr_wdata),
    .advance   (ptr_advance),
    .wrap_flag (ptr_wrap),
    .desc_addr (desc_addr)
  );

  rxq_word_pack #(
    .DW        (DW),
    .BUF_BYTES (BUF_BYTES)
  ) pack_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (pack_clr),
    .push         (pack_push),
    .byte_in      (in_data),
    .word         (pack_word),
    .word_idx     (pack_widx),
    .last_in_word (pack_last_word),
    .last_in_buf  (pack_last_buf)
  );

  rxq_rx_ctrl #(
    .AW        (AW),
    .DW        (DW),
    .BUF_BYTES (BUF_BYTES)
  ) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_en          (rx_en),
    .in_valid       (in_valid),
    .in_sof         (in_sof),
    .in_eof         (in_eof),
    .in_ready       (in_ready),
    .mem_req        (mem_req),
    .mem_gnt        (mem_gnt),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .desc_addr      (desc_addr),
    .pack_word      (pack_word),
    .pack_widx      (pack_widx),
    .pack_last_word (pack_last_word),
    .pack_last_buf  (pack_last_buf),
    .pack_push      (pack_push),
    .pack_clr       (pack_clr),
    .ptr_advance    (ptr_advance),
    .ptr_wrap       (ptr_wrap),
    .load_ok        (load_ok),
    .bna            (bna)
  );
endmodule

// File: rtl/rxq_ring_dma_chk.sv
module rxq_ring_dma_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          bna
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R10
  AST_NO_BYTE_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready); // R10
  AST_STOPPED_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    bna |-> !mem_req); // R7
  AST_STOP_CLEARS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bna) |-> !$past(rx_en)); // R7
endmodule

bind rxq_ring_dma rxq_ring_dma_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .in_ready  (in_ready),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .bna       (bna)
);

// File: tb/rxq_ring_dma_tb_top.sv
module rxq_ring_dma_tb_top;
  localparam int MEM_WORDS = 4352;
  localparam int MR_BASE   = 32'h100;
  localparam int MR_N      = 3;
  localparam int MR_BUF    = 32'h400;
  localparam int ALT_BASE  = 32'h800;
  localparam int BIG_BASE  = 32'h2000;
  localparam int BIG_BUF   = 32'h600;
  localparam int SENTINEL  = 32'h4000;
  localparam logic [31:0] FILLV = 32'hA5A5A5A5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, rx_en, qptr_we;
  logic [31:0] qptr_wdata;
  logic        in_valid, in_ready, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        mem_req, mem_gnt, mem_we, mem_rvalid, bna;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  rxq_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .qptr_we(qptr_we), .qptr_wdata(qptr_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .bna(bna)
  );

  logic [31:0] mem [0:MEM_WORDS-1];
  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  bit done = 0;

  // memory responder: grant decided at the falling edge, read data one cycle later
  initial begin
    bit rd_pend;
    logic [31:0] rd_data;
    int cyc;
    rd_pend = 0; rd_data = '0; cyc = 0;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_data;
        rd_pend    = 0;
      end
      mem_gnt = ((cyc % 3) != 1);
      cyc++;
      #1;
      if (rst_n && mem_req && mem_gnt) begin
        if (mem_addr[31:2] >= 30'(MEM_WORDS)) begin
          errors++;
          $display("FAIL R10 address out of range act=%h exp=<%h", mem_addr, MEM_WORDS * 4);
        end else if (mem_we) begin
          mem[mem_addr[15:2]] = mem_wdata;
          wr_count++;
        end else begin
          rd_pend = 1;
          rd_data = mem[mem_addr[15:2]];
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 7 + i) & 255);
  endfunction

  task automatic send_frame(input int id, input int len);
    for (int i = 0; i < len; i++) send_byte(pat(id, i), i == 0, i == len - 1);
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 4) begin
      @(negedge clk); #2;
      if (mem_req) q = 0; else q++;
    end
  endtask

  task automatic write_qptr(input logic [31:0] a);
    @(negedge clk); qptr_we = 1'b1; qptr_wdata = a;
    @(negedge clk); qptr_we = 1'b0;
  endtask

  function automatic logic [31:0] mr_w0(input int d);
    return 32'(MR_BUF + d * 128) | ((d == MR_N - 1) ? 32'h2 : 32'h0);
  endfunction

  task automatic arm_main(input int d);
    mem[(MR_BASE + 8 * d) / 4]     = mr_w0(d);
    mem[(MR_BASE + 8 * d) / 4 + 1] = 32'hFFFF_FFFF;
    for (int w = 0; w < 32; w++) mem[(MR_BUF + d * 128) / 4 + w] = FILLV;
  endtask

  // checks buffers of one frame, re-arms them and advances the expected ring position
  task automatic check_frame(input int id, input int len, inout int cur);
    int nb;
    nb = (len + 127) / 128;
    for (int b = 0; b < nb; b++) begin
      int blen, tot;
      logic [31:0] e1;
      blen = (len - b * 128 > 128) ? 128 : len - b * 128;
      tot  = b * 128 + blen;
      e1   = 32'(tot) | ((b == 0) ? 32'h4000_0000 : 0) | ((b == nb - 1) ? 32'h8000_0000 : 0);
      check("R5 word0 ownership writeback", mem[(MR_BASE + 8 * cur) / 4], mr_w0(cur) | 32'h1);
      check("R4 word1 status", mem[(MR_BASE + 8 * cur) / 4 + 1], e1);
      for (int w = 0; w < (blen + 3) / 4; w++) begin
        logic [31:0] ew;
        ew = '0;
        for (int k = 0; k < 4; k++)
          if (w * 4 + k < blen) ew[8*k +: 8] = pat(id, b * 128 + w * 4 + k);
        check("R2 R3 buffer data", mem[(MR_BUF + cur * 128) / 4 + w], ew);
      end
      if (blen < 125) check("R2 unused word untouched", mem[(MR_BUF + cur * 128) / 4 + (blen + 3) / 4], FILLV);
      arm_main(cur);
      cur = (cur + 1) % MR_N;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cur, id, wc;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    rst_n = 0; rx_en = 0; qptr_we = 0; qptr_wdata = '0;
    in_valid = 0; in_data = '0; in_sof = 0; in_eof = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check("R9 reset in_ready", 32'(in_ready), 32'h1);
    check("R10 reset mem_req", 32'(mem_req), 32'h0);
    check("R7 reset bna", 32'(bna), 32'h0);

    for (int d = 0; d < MR_N; d++) arm_main(d);
    write_qptr(MR_BASE);

    // R9: traffic while disabled is dropped
    wc = wr_count;
    send_frame(99, 5);
    wait_quiet();
    check("R9 disabled frame no writes", 32'(wr_count), 32'(wc));

    rx_en = 1;
    // R9: bytes without start marker while idle
    send_byte(8'h11, 0, 0);
    send_byte(8'h22, 0, 1);
    wait_quiet();
    check("R9 stray bytes no writes", 32'(wr_count), 32'(wc));

    // R1 R2 R3 R4 R5 R6: length sweep over a three-entry ring with wrap flag
    cur = 0; id = 1;
    for (int len = 1; len <= 140; len++) begin
      send_frame(id, len); wait_quiet(); check_frame(id, len, cur); id++;
    end
    for (int len = 250; len <= 260; len++) begin
      send_frame(id, len); wait_quiet(); check_frame(id, len, cur); id++;
    end

    // R8: pointer write while enabled is ignored
    mem[ALT_BASE / 4] = 32'h0000_0700; mem[ALT_BASE / 4 + 1] = 32'hFFFF_FFFF;
    write_qptr(ALT_BASE);
    send_frame(id, 10); wait_quiet(); check_frame(id, 10, cur); id++;
    check("R8 alt ring untouched", mem[ALT_BASE / 4 + 1], 32'hFFFF_FFFF);

    // R7: descriptor held by software at frame start
    mem[(MR_BASE + 8 * cur) / 4] = mr_w0(cur) | 32'h1;
    wc = wr_count;
    send_frame(id, 20); wait_quiet();
    check("R7 bna raised", 32'(bna), 32'h1);
    check("R7 no writes", 32'(wr_count), 32'(wc));
    send_frame(id + 1, 5); wait_quiet();
    check("R7 stays stopped", 32'(wr_count), 32'(wc));
    check("R7 bna held", 32'(bna), 32'h1);
    @(negedge clk); rx_en = 0;
    repeat (3) @(negedge clk); #2;
    check("R7 bna clears when disabled", 32'(bna), 32'h0);
    arm_main(cur);
    rx_en = 1;
    send_frame(id, 9); wait_quiet(); check_frame(id, 9, cur); id++;

    // R7 R3: next buffer held by software in mid-frame
    begin
      int nx;
      nx = (cur + 1) % MR_N;
      mem[(MR_BASE + 8 * nx) / 4] = mr_w0(nx) | 32'h1;
      send_frame(id, 200); wait_quiet();
      check("R7 bna mid-frame", 32'(bna), 32'h1);
      check("R4 first buffer status no end flag", mem[(MR_BASE + 8 * cur) / 4 + 1], 32'h4000_0080);
      check("R5 first buffer handed over", mem[(MR_BASE + 8 * cur) / 4], mr_w0(cur) | 32'h1);
      check("R7 held descriptor untouched", mem[(MR_BASE + 8 * nx) / 4 + 1], 32'hFFFF_FFFF);
      for (int w = 0; w < 32; w++) begin
        logic [31:0] ew;
        for (int k = 0; k < 4; k++) ew[8*k +: 8] = pat(id, w * 4 + k);
        check("R3 first buffer data", mem[(MR_BUF + cur * 128) / 4 + w], ew);
      end
      id++;
    end

    // R6 R8: implicit wrap after a full ring of 1024 entries
    @(negedge clk); rx_en = 0;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 1024; d++) begin
      mem[BIG_BASE / 4 + 2 * d]     = BIG_BUF;
      mem[BIG_BASE / 4 + 2 * d + 1] = 32'hFFFF_FFFF;
    end
    mem[SENTINEL / 4] = BIG_BUF | 32'h1; mem[SENTINEL / 4 + 1] = 32'hFFFF_FFFF;
    write_qptr(BIG_BASE);
    rx_en = 1;
    send_frame(id, 1); wait_quiet();
    check("R8 load restarts at first entry", mem[BIG_BASE / 4 + 1], 32'hC000_0001);
    for (int f = 1; f < 1024; f++) send_frame(id + f, 1);
    wait_quiet();
    check("R6 last entry filled", mem[BIG_BASE / 4 + 2 * 1023 + 1], 32'hC000_0001);
    mem[BIG_BASE / 4] = BIG_BUF; mem[BIG_BASE / 4 + 1] = 32'hFFFF_FFFF;
    send_frame(id, 3); wait_quiet();
    check("R6 implicit wrap reuses first entry", mem[BIG_BASE / 4 + 1], 32'hC000_0003);
    check("R6 no stop after wrap", 32'(bna), 32'h0);
    check("R6 sentinel untouched", mem[SENTINEL / 4 + 1], 32'hFFFF_FFFF);
    check("R2 three-byte word", mem[BIG_BUF / 4], {8'h00, pat(id, 2), pat(id, 1), pat(id, 0)});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule